// File: doc/BRIEF.md
# Power-Good and Zero-Current Monitor

This block sits in the digital control of a single-port power-sourcing switch. It takes two comparator results: "output is close to the supply" and "load current is below the zero-current threshold". From the first it builds a power-good flag with a long qualification delay on the way up and a short one on the way down. From the second it decides that the powered device has been unplugged. That decision latches an active-low zero-current flag and issues a one-cycle disconnect request, which tells the switch controller to turn the switch off and start detection again.

All delays are counted in ticks of an external timebase strobe, 100 µs by default. The defaults therefore give 88 ms for power-good rise, 1.4 ms for its fall, 350 ms for the zero-current trip and 10 ms for the current-return deglitch. Zero-current monitoring runs only while its enable input is high and power-good is already asserted. The latched flag is cleared in one of two ways. In normal operation it clears when the next powered device is detected. When detection is bypassed, the block instead holds the switch off until the port enable is dropped.

The power-good state machine has four states: POK_LOW, POK_QUAL_UP (near-supply seen, counting rise ticks), POK_HIGH and POK_QUAL_DN (near-supply lost, counting fall ticks). Its transitions are:
- POK_LOW to POK_QUAL_UP when near-supply is seen.
- POK_QUAL_UP to POK_HIGH when the rise count completes.
- POK_QUAL_UP back to POK_LOW on any cycle without near-supply.
- POK_HIGH to POK_QUAL_DN when near-supply is lost.
- POK_QUAL_DN to POK_LOW when the fall count completes.
- POK_QUAL_DN back to POK_HIGH on any cycle with near-supply.
- Any state to POK_LOW when the port enable is low.

The zero-current state machine has four states: ZC_IDLE, ZC_COUNT (current below threshold, trip timer running), ZC_DEGLITCH (current back, trip timer frozen, deglitch timer running) and ZC_LATCHED. Its transitions are:
- ZC_IDLE or ZC_DEGLITCH to ZC_COUNT on low current.
- ZC_COUNT to ZC_DEGLITCH when current returns.
- ZC_DEGLITCH to ZC_IDLE when the deglitch count completes, which also clears the trip timer.
- ZC_COUNT to ZC_LATCHED when the trip count completes.
- ZC_LATCHED to ZC_IDLE on a detection pulse, in normal mode only.
- Any state to ZC_IDLE when the port enable or the monitor enable is low.
- Any non-latched state to ZC_IDLE when power-good is low.

Top module: `pwr_good_zc_mon`

## Requirements
- R1: `pok_o` rises one clock after the edge on which the POK_RISE_TICKS-th consecutive tick with `near_supply_i` high is sampled.
- R2: `pok_o` falls one clock after the edge on which the POK_FALL_TICKS-th consecutive tick with `near_supply_i` low is sampled.
- R3: A single clock of the opposite comparator level during either qualification restarts that count from zero, and `pok_o` keeps its value.
- R4: Trip ticks are counted only while `zc_en_i` and `pok_o` are both high and `under_zc_i` is high. When ZC_TRIP_TICKS such ticks have been counted, `zc_n_o` goes low (0 = zero-current fault latched).
- R5: If current returns for fewer than ZC_GLITCH_TICKS ticks, the trip count is held and resumes afterwards. If current stays above threshold for ZC_GLITCH_TICKS ticks, the trip count is cleared.
- R6: On a trip, `disconnect_o` is high for exactly one clock, in the cycle `zc_n_o` first reads low. In normal mode (`det_disable_i` = 0 at the trip), `zc_n_o` stays low, regardless of power-good, until a `pd_detected_i` pulse releases it one clock later.
- R7: If `det_disable_i` = 1 at the trip, `hold_off_o` rises together with `zc_n_o` falling. `pd_detected_i` is then ignored, and both flags stay set until `en_i` goes low.
- R8: While `zc_en_i` is low, `zc_n_o` reads 1 from the next clock on, even if a fault was latched, and both timers are cleared.
- R9: With `en_i` low, `pok_o` is 0, `zc_n_o` is 1 and `hold_off_o` is 0 from the next clock, and every count restarts.
- R10: After reset, `pok_o` = 0, `zc_n_o` = 1, `disconnect_o` = 0 and `hold_off_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Port enable; low clears everything |
| near_supply_i | input | 1 | Output within power-good window of the supply |
| under_zc_i | input | 1 | Load current below zero-current threshold |
| zc_en_i | input | 1 | Zero-current monitoring enable |
| det_disable_i | input | 1 | Detection bypass mode |
| pd_detected_i | input | 1 | One-clock pulse: valid device detected |
| tick_i | input | 1 | Timebase strobe (100 µs default) |
| pok_o | output | 1 | Power-good flag |
| zc_n_o | output | 1 | Zero-current fault flag, active low |
| disconnect_o | output | 1 | One-clock request: switch off and redetect |
| hold_off_o | output | 1 | Keep switch off until enable is dropped |

## Verification
Every output is registered. Each result is therefore due one clock after the edge that samples the deciding input: the last counted tick, the detection pulse, or the enable drop. The bench drives inputs and samples outputs on the falling edge. A behavioural reference model, advanced on every rising edge, predicts the value each output must show at the following falling edge, and all four outputs are compared there on every cycle. Targeted checks also count the falling edges between a stimulus and the resulting flag change, and compare that count with the tick arithmetic in the requirements, including a resumed trip count after a short current return.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    typedef enum logic [1:0] {
        POK_LOW     = 2'd0,
        POK_QUAL_UP = 2'd1,
        POK_HIGH    = 2'd2,
        POK_QUAL_DN = 2'd3
    } pok_state_e;

    typedef enum logic [1:0] {
        ZC_IDLE     = 2'd0,
        ZC_COUNT    = 2'd1,
        ZC_DEGLITCH = 2'd2,
        ZC_LATCHED  = 2'd3
    } zc_state_e;

endpackage

// File: rtl/pgm_pok_filter.sv
module pgm_pok_filter
    import pgm_pkg::*;
#(
    parameter int RISE_TICKS = 880,
    parameter int FALL_TICKS = 14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic near_i,
    input  logic tick_i,
    output logic pok_o
);
    localparam int RW = $clog2(RISE_TICKS + 1);
    localparam int FW = $clog2(FALL_TICKS + 1);
    localparam int CW = (RW > FW) ? RW : FW;
    localparam logic [CW-1:0] RISE_LAST = CW'(RISE_TICKS - 1);
    localparam logic [CW-1:0] FALL_LAST = CW'(FALL_TICKS - 1);

    pok_state_e     state_q, state_d;
    logic [CW-1:0]  cnt_q, cnt_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= POK_LOW;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!en_i) begin
            state_d = POK_LOW;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                POK_LOW, POK_QUAL_UP: begin
                    if (near_i) begin
                        state_d = POK_QUAL_UP;
                        if (tick_i) begin
                            if (cnt_q == RISE_LAST) begin
                                state_d = POK_HIGH;
                                cnt_d   = '0;
                            end else begin
                                cnt_d = cnt_q + 1'b1;
                            end
                        end
                    end else begin
                        state_d = POK_LOW;
                        cnt_d   = '0;
                    end
                end
                POK_HIGH, POK_QUAL_DN: begin
                    if (!near_i) begin
                        state_d = POK_QUAL_DN;
                        if (tick_i) begin
                            if (cnt_q == FALL_LAST) begin
                                state_d = POK_LOW;
                                cnt_d   = '0;
                            end else begin
                                cnt_d = cnt_q + 1'b1;
                            end
                        end
                    end else begin
                        state_d = POK_HIGH;
                        cnt_d   = '0;
                    end
                end
                default: begin
                    state_d = POK_LOW;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        pok_o = (state_q == POK_HIGH) || (state_q == POK_QUAL_DN);
    end

    p_rise_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pok_o) |-> $past(en_i && near_i && tick_i));
    p_fall_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pok_o) |-> $past(!en_i || (!near_i && tick_i)));
    p_hold_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pok_o && near_i && en_i) |=> pok_o);
    p_en_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pok_o);

endmodule

// File: rtl/pgm_zc_monitor.sv
module pgm_zc_monitor
    import pgm_pkg::*;
#(
    parameter int TRIP_TICKS   = 3500,
    parameter int GLITCH_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic zc_en_i,
    input  logic pok_i,
    input  logic under_i,
    input  logic det_dis_i,
    input  logic pd_det_i,
    input  logic tick_i,
    output logic zc_n_o,
    output logic disc_o,
    output logic hold_off_o
);
    localparam int TW = $clog2(TRIP_TICKS + 1);
    localparam int GW = $clog2(GLITCH_TICKS + 1);
    localparam logic [TW-1:0] TRIP_LAST   = TW'(TRIP_TICKS - 1);
    localparam logic [GW-1:0] GLITCH_LAST = GW'(GLITCH_TICKS - 1);

    zc_state_e      state_q, state_d;
    logic [TW-1:0]  trip_q, trip_d;
    logic [GW-1:0]  glit_q, glit_d;
    logic           det_q, det_d;
    logic           trip_now;
    logic           disc_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ZC_IDLE;
            trip_q  <= '0;
            glit_q  <= '0;
            det_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            trip_q  <= trip_d;
            glit_q  <= glit_d;
            det_q   <= det_d;
        end
    end

    // next state
    always_comb begin
        state_d  = state_q;
        trip_d   = trip_q;
        glit_d   = glit_q;
        det_d    = det_q;
        trip_now = 1'b0;
        if (!en_i || !zc_en_i) begin
            state_d = ZC_IDLE;
            trip_d  = '0;
            glit_d  = '0;
            det_d   = 1'b0;
        end else begin
            unique case (state_q)
                ZC_LATCHED: begin
                    if (!det_q && pd_det_i) begin
                        state_d = ZC_IDLE;
                        det_d   = 1'b0;
                    end
                end
                ZC_IDLE, ZC_COUNT, ZC_DEGLITCH: begin
                    if (!pok_i) begin
                        state_d = ZC_IDLE;
                        trip_d  = '0;
                        glit_d  = '0;
                    end else if (under_i) begin
                        state_d = ZC_COUNT;
                        glit_d  = '0;
                        if (tick_i) begin
                            if (trip_q == TRIP_LAST) begin
                                state_d  = ZC_LATCHED;
                                trip_d   = '0;
                                det_d    = det_dis_i;
                                trip_now = 1'b1;
                            end else begin
                                trip_d = trip_q + 1'b1;
                            end
                        end
                    end else if (state_q != ZC_IDLE) begin
                        state_d = ZC_DEGLITCH;
                        if (tick_i) begin
                            if (glit_q == GLITCH_LAST) begin
                                state_d = ZC_IDLE;
                                trip_d  = '0;
                                glit_d  = '0;
                            end else begin
                                glit_d = glit_q + 1'b1;
                            end
                        end
                    end
                end
                default: begin
                    state_d = ZC_IDLE;
                end
            endcase
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            disc_q <= 1'b0;
        end else begin
            disc_q <= trip_now;
        end
    end

    always_comb begin
        zc_n_o     = (state_q != ZC_LATCHED);
        hold_off_o = (state_q == ZC_LATCHED) && det_q;
        disc_o     = disc_q;
    end

    p_trip_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(zc_n_o) |-> $past(en_i && zc_en_i && pok_i && under_i && tick_i));
    p_disc_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disc_o |=> !disc_o);
    p_disc_with_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        disc_o |-> !zc_n_o);
    p_release_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(zc_n_o) |-> $past(!en_i || !zc_en_i || pd_det_i));
    p_hold_is_latched_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold_off_o |-> !zc_n_o);
    p_hold_ignores_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_off_o && en_i && zc_en_i) |=> hold_off_o);
    p_off_releases_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!zc_en_i || !en_i) |=> (zc_n_o && !hold_off_o));

endmodule

// File: rtl/pwr_good_zc_mon.sv
module pwr_good_zc_mon #(
    parameter int POK_RISE_TICKS  = 880,
    parameter int POK_FALL_TICKS  = 14,
    parameter int ZC_TRIP_TICKS   = 3500,
    parameter int ZC_GLITCH_TICKS = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic near_supply_i,
    input  logic under_zc_i,
    input  logic zc_en_i,
    input  logic det_disable_i,
    input  logic pd_detected_i,
    input  logic tick_i,
    output logic pok_o,
    output logic zc_n_o,
    output logic disconnect_o,
    output logic hold_off_o
);
    logic pok_w;

    pgm_pok_filter #(
        .RISE_TICKS (POK_RISE_TICKS),
        .FALL_TICKS (POK_FALL_TICKS)
    ) u_pok (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (en_i),
        .near_i (near_supply_i),
        .tick_i (tick_i),
        .pok_o  (pok_w)
    );

    pgm_zc_monitor #(
        .TRIP_TICKS   (ZC_TRIP_TICKS),
        .GLITCH_TICKS (ZC_GLITCH_TICKS)
    ) u_zc (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (en_i),
        .zc_en_i    (zc_en_i),
        .pok_i      (pok_w),
        .under_i    (under_zc_i),
        .det_dis_i  (det_disable_i),
        .pd_det_i   (pd_detected_i),
        .tick_i     (tick_i),
        .zc_n_o     (zc_n_o),
        .disc_o     (disconnect_o),
        .hold_off_o (hold_off_o)
    );

    assign pok_o = pok_w;

    p_reset_idle_r10: assert property (@(posedge clk)
        !rst_n |=> (!pok_o && zc_n_o && !disconnect_o && !hold_off_o));

endmodule

// File: tb/pwr_good_zc_mon_tb.sv
module pwr_good_zc_mon_tb_top;
    localparam time CLK_PERIOD = 10ns;
    localparam int RISE  = 20;
    localparam int FALL  = 5;
    localparam int TRIP  = 40;
    localparam int GLIT  = 8;
    localparam int WDOG  = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, near = 1'b0, under = 1'b0, zc_en = 1'b0;
    logic det_dis = 1'b0, pd = 1'b0, tick = 1'b0;
    logic pok, zc_n, disc, hold;

    int checks = 0, fails = 0, cycles = 0, tick_div = 1, tcnt = 0, disc_seen = 0;
    string phase = "R10";

    // reference model state
    int m_pc = 0, m_trip = 0, m_dg = 0;
    bit m_pok = 0, m_cnt = 0, m_lat = 0, m_latdet = 0, m_disc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pwr_good_zc_mon #(
        .POK_RISE_TICKS(RISE), .POK_FALL_TICKS(FALL),
        .ZC_TRIP_TICKS(TRIP), .ZC_GLITCH_TICKS(GLIT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .near_supply_i(near),
        .under_zc_i(under), .zc_en_i(zc_en), .det_disable_i(det_dis),
        .pd_detected_i(pd), .tick_i(tick), .pok_o(pok), .zc_n_o(zc_n),
        .disconnect_o(disc), .hold_off_o(hold)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // behavioural reference, advanced on each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            m_pc = 0; m_trip = 0; m_dg = 0;
            m_pok = 0; m_cnt = 0; m_lat = 0; m_latdet = 0; m_disc = 0;
        end else begin
            m_disc = 0;
            if (!en || !zc_en) begin
                m_lat = 0; m_latdet = 0; m_cnt = 0; m_trip = 0; m_dg = 0;
            end else if (m_lat) begin
                if (!m_latdet && pd) m_lat = 0;
            end else if (!m_pok) begin
                m_cnt = 0; m_trip = 0; m_dg = 0;
            end else if (under) begin
                m_cnt = 1; m_dg = 0;
                if (tick) begin
                    m_trip++;
                    if (m_trip == TRIP) begin
                        m_lat = 1; m_latdet = det_dis; m_disc = 1;
                        m_trip = 0; m_cnt = 0;
                    end
                end
            end else if (m_cnt && tick) begin
                m_dg++;
                if (m_dg == GLIT) begin m_cnt = 0; m_trip = 0; m_dg = 0; end
            end
            if (!en) begin
                m_pok = 0; m_pc = 0;
            end else if (!m_pok) begin
                if (near) begin
                    if (tick) begin m_pc++; if (m_pc == RISE) begin m_pok = 1; m_pc = 0; end end
                end else m_pc = 0;
            end else begin
                if (!near) begin
                    if (tick) begin m_pc++; if (m_pc == FALL) begin m_pok = 0; m_pc = 0; end end
                end else m_pc = 0;
            end
        end
    end

    // per-cycle comparison and tick generation, away from the rising edge
    always @(negedge clk) begin
        if (cycles >= 2) begin
            check(phase, "pok_o", pok, m_pok);
            check(phase, "zc_n_o", zc_n, !m_lat);
            check(phase, "disconnect_o", disc, m_disc);
            check(phase, "hold_off_o", hold, m_lat && m_latdet);
        end
        if (disc === 1'b1) disc_seen++;
        tcnt = (tcnt + 1) % tick_div;
        tick <= (tcnt == 0);
    end

    always @(posedge clk) begin
        if (cycles > WDOG) begin
            fails++;
            $display("FAIL R10 watchdog actual=%0d expected<=%0d", cycles, WDOG);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_pok(input bit lvl);
        for (int i = 0; i < 1000 && pok !== lvl; i++) @(negedge clk);
    endtask

    task automatic wait_zc_low(output int n);
        n = 0;
        while (zc_n !== 1'b0 && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int n;
        step(4);
        rst_n = 1'b1;
        step(1);
        // R10 reset state
        check("R10", "pok_o", pok, 0);
        check("R10", "zc_n_o", zc_n, 1);
        check("R10", "disconnect_o", disc, 0);
        check("R10", "hold_off_o", hold, 0);

        // R3 dropout restarts rise count, R1 rise delay
        phase = "R3"; en = 1; near = 1; step(RISE - 2);
        near = 0; step(1); near = 1;
        phase = "R1"; n = 0;
        while (pok !== 1'b1 && n < 500) begin @(negedge clk); n++; end
        check("R1", "rise delay in clocks", n, RISE);

        // R3 short fall-side dropout keeps pok, R2 fall delay
        phase = "R3"; near = 0; step(FALL - 1); near = 1; step(3);
        check("R3", "pok_o after short dropout", pok, 1);
        phase = "R2"; near = 0; n = 0;
        while (pok !== 1'b0 && n < 500) begin @(negedge clk); n++; end
        check("R2", "fall delay in clocks", n, FALL);
        near = 1; phase = "R1"; wait_pok(1);

        // R8 monitor disabled
        phase = "R8"; under = 1; step(TRIP + 10);
        check("R8", "zc_n_o with monitor off", zc_n, 1);

        // R5 short current return holds the trip count; R4 trip; R6 pulse
        phase = "R5"; zc_en = 1; disc_seen = 0; step(TRIP / 2);
        under = 0; step(GLIT - 3); under = 1;
        wait_zc_low(n);
        check("R5", "clocks to trip after short return", n, TRIP - TRIP / 2);
        phase = "R6"; step(2);
        check("R6", "disconnect pulses", disc_seen, 1);
        near = 0; step(FALL + 5);
        check("R6", "zc_n_o held with pok low", zc_n, 0);
        pd = 1; step(1); pd = 0;
        check("R6", "zc_n_o after detection", zc_n, 1);

        // R5 sustained current return clears the trip count
        phase = "R5"; near = 1; under = 0; wait_pok(1);
        under = 1; step(10); under = 0; step(GLIT); under = 1;
        wait_zc_low(n);
        check("R5", "clocks to trip after full return", n, TRIP);

        // R7 detection-bypass latch ignores pd and clears on enable low
        phase = "R7"; det_dis = 1; pd = 1; step(1); pd = 0;
        wait_zc_low(n);
        check("R7", "hold_off_o on trip", hold, 1);
        pd = 1; step(1); pd = 0; step(3);
        check("R7", "zc_n_o after ignored pd", zc_n, 0);
        check("R7", "hold_off_o after ignored pd", hold, 1);
        phase = "R9"; en = 0; step(1);
        check("R9", "zc_n_o on enable low", zc_n, 1);
        check("R9", "hold_off_o on enable low", hold, 0);
        check("R9", "pok_o on enable low", pok, 0);

        // R8 monitor enable low releases a latched fault
        phase = "R8"; en = 1; det_dis = 0; wait_pok(1);
        wait_zc_low(n);
        check("R4", "trip reached", zc_n, 0);
        zc_en = 0; step(1);
        check("R8", "zc_n_o after monitor off", zc_n, 1);

        // R1 R2 with a slower timebase
        phase = "R2"; tick_div = 3; zc_en = 1; under = 0;
        near = 0; wait_pok(0);
        phase = "R1"; near = 1; wait_pok(1);
        check("R1", "pok_o with slow tick", pok, 1);
        phase = "R4"; under = 1; wait_zc_low(n);
        check("R4", "trip with slow tick", zc_n, 0);
        step(5);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule